// File: doc/BRIEF.md
# CAN Node Status and Status-Interrupt Logic

This block keeps the status byte of a CAN controller and raises the status-interrupt condition. The error counter logic supplies the transmit and receive error counts, a receive-passive flag and a bus-off flag. From these the block derives three read-only error-state bits: warning, error-passive and bus-off. The bit-stream engine pulses strobes when a frame is sent correctly, when a frame is received correctly, and when a new last-error code is known. The block turns those pulses into the sticky transfer-status fields.

A status interrupt code is raised only by hardware. The error-interrupt enable covers changes of the bus-off or warning bit. The status-interrupt enable covers changes of the transfer-status fields. The CPU may overwrite the transfer-status fields, but such a write never raises a code. Reading the status byte clears the code. The global interrupt enable gates the interrupt line.

All pins are plain control or status levels. No data moves as a stream, so there is no valid/ready handshake and no back-pressure. Every input is sampled on every rising edge of `clk`.

Top module: `can_status_unit`

## Requirements
- R1: `warn` is 1 one cycle after an edge at which `tx_err_cnt` or `rx_err_cnt` is 96 or more, and 0 one cycle after an edge at which both are below 96.
- R2: `err_passive` is 1 one cycle after an edge at which `rx_passive` is 1 or `tx_err_cnt` is 128 or more. A change of `err_passive` alone never sets the interrupt code.
- R3: `bus_off` equals the value `bus_off_in` had at the previous edge. The three error-state bits have no CPU write path, and a CPU write leaves them unchanged.
- R4: `stat_rdata` shows the status byte at all times: bit 7 bus-off, bit 6 error-passive, bit 5 warning, bit 4 transmit-OK, bit 3 receive-OK, bits 2:0 last error code.
- R5: A pulse on `ev_tx_ok` or `ev_rx_ok` sets the matching OK bit to 1, and `ev_lec_upd` loads `ev_lec` into the last error code. A `cpu_wr` loads `cpu_wdata` (bit 4 transmit-OK, bit 3 receive-OK, bits 2:0 last error code) and overrides any hardware event in the same cycle.
- R6: When `err_ie` is 1, a hardware change of the bus-off or warning bit makes `int_code` read 0x8000 from the cycle in which the new bit value is visible.
- R7: When `sts_ie` is 1, a hardware event that changes transmit-OK, receive-OK or the last error code sets `int_code` to 0x8000 in the same way. An event that leaves the value unchanged sets nothing.
- R8: A CPU write to the transfer-status fields never sets the interrupt code.
- R9: A `cpu_rd` clears `int_code` to 0 at the next edge, unless a new cause arrives at that same edge, in which case the code stays 0x8000.
- R10: `irq` is 1 exactly when `int_code` is nonzero and `glob_ie` is 1. A change that happened while its enable was 0 is not raised later when the enable is set.
- R11: After reset every status bit, `int_code` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err_cnt | input | 8 | Transmit error count |
| rx_err_cnt | input | 8 | Receive error count |
| rx_passive | input | 1 | Receive counter is in the passive range |
| bus_off_in | input | 1 | Node is in the bus-off state |
| ev_tx_ok | input | 1 | Pulse: frame transmitted without error |
| ev_rx_ok | input | 1 | Pulse: frame received without error |
| ev_lec_upd | input | 1 | Pulse: new last error code on `ev_lec` |
| ev_lec | input | 3 | Last error code value |
| err_ie | input | 1 | Enable codes from bus-off or warning changes |
| sts_ie | input | 1 | Enable codes from transfer-status changes |
| glob_ie | input | 1 | Global interrupt enable |
| cpu_wr | input | 1 | CPU write strobe for the transfer-status fields |
| cpu_wdata | input | 5 | Write data: bit 4 transmit-OK, bit 3 receive-OK, bits 2:0 last error code |
| cpu_rd | input | 1 | CPU read strobe of the status byte; clears the code |
| stat_rdata | output | 8 | Status byte |
| warn | output | 1 | Warning bit |
| err_passive | output | 1 | Error-passive bit |
| bus_off | output | 1 | Bus-off bit |
| int_code | output | 16 | Status interrupt code, 0x8000 or 0 |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach is the collision at a single edge. A read that clears the code lands on the same edge as a fresh hardware cause, or a CPU write lands on the same edge as a transfer event that would otherwise change the field. Directed steps set up each collision on purpose. The random phase then draws the counters mostly from the values on either side of 96 and 128, and it fires the strobes, reads and writes independently and often. This makes such coincidences occur many times, and a bench reference model predicts every outcome.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

  localparam int unsigned LEC_W = 3;
  localparam int unsigned CODE_W = 16;
  localparam logic [CODE_W-1:0] STATUS_CODE = 16'h8000;

  // Status byte as seen by the CPU, MSB first
  typedef struct packed {
    logic             bus_off;
    logic             passive;
    logic             warn;
    logic             tx_ok;
    logic             rx_ok;
    logic [LEC_W-1:0] lec;
  } stat_byte_t;

  // Writable part of the status byte
  typedef struct packed {
    logic             tx_ok;
    logic             rx_ok;
    logic [LEC_W-1:0] lec;
  } xfer_fields_t;

endpackage

// File: rtl/can_err_level.sv
module can_err_level #(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned WARN_LEVEL    = 96,
  parameter int unsigned PASSIVE_LEVEL = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             rx_passive,
  input  logic             bus_off_in,
  output logic             warn_q,
  output logic             passive_q,
  output logic             bus_off_q,
  output logic             err_chg
);

  localparam int unsigned N_CNT = 2;
  localparam logic [CNT_W-1:0] WARN_L = WARN_LEVEL[CNT_W-1:0];
  localparam logic [CNT_W-1:0] PASS_L = PASSIVE_LEVEL[CNT_W-1:0];

  logic [CNT_W-1:0] cnt_arr [N_CNT];
  logic [N_CNT-1:0] over_warn;
  logic             warn_d, passive_d;

  assign cnt_arr[0] = tx_cnt;
  assign cnt_arr[1] = rx_cnt;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cmp
    assign over_warn[g] = (cnt_arr[g] >= WARN_L);
  end

  assign warn_d    = |over_warn;
  assign passive_d = rx_passive | (tx_cnt >= PASS_L);

  // Only bus-off and warning transitions are interrupt causes
  assign err_chg = (warn_d != warn_q) | (bus_off_in != bus_off_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q    <= 1'b0;
      passive_q <= 1'b0;
      bus_off_q <= 1'b0;
    end else begin
      warn_q    <= warn_d;
      passive_q <= passive_d;
      bus_off_q <= bus_off_in;
    end
  end

  AST_WARN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> warn_q == (($past(tx_cnt) >= WARN_L) || ($past(rx_cnt) >= WARN_L))); // R1
  AST_PASSIVE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> passive_q == ($past(rx_passive) || ($past(tx_cnt) >= PASS_L))); // R2
  AST_BOFF_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bus_off_q == $past(bus_off_in)); // R3

endmodule

// File: rtl/can_xfer_status.sv
module can_xfer_status
  import can_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_tx_ok,
  input  logic             ev_rx_ok,
  input  logic             ev_lec_upd,
  input  logic [LEC_W-1:0] ev_lec,
  input  logic             cpu_wr,
  input  xfer_fields_t     cpu_fields,
  output xfer_fields_t     fields_q,
  output logic             hw_chg
);

  xfer_fields_t hw_next, fields_d;

  always_comb begin
    hw_next = fields_q;
    if (ev_tx_ok)   hw_next.tx_ok = 1'b1;
    if (ev_rx_ok)   hw_next.rx_ok = 1'b1;
    if (ev_lec_upd) hw_next.lec   = ev_lec;
  end

  // A CPU write wins and suppresses hardware change detection
  assign fields_d = cpu_wr ? cpu_fields : hw_next;
  assign hw_chg   = !cpu_wr && (hw_next != fields_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fields_q <= '0;
    else        fields_q <= fields_d;
  end

  AST_TXOK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_ok && !cpu_wr) |=> fields_q.tx_ok); // R5
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> fields_q == $past(cpu_fields)); // R5
  AST_WRITE_NO_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> !hw_chg); // R8

endmodule

// File: rtl/can_int_code.sv
module can_int_code
  import can_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_ie,
  input  logic              sts_ie,
  input  logic              glob_ie,
  input  logic              err_chg,
  input  logic              sts_chg,
  input  logic              cpu_rd,
  output logic [CODE_W-1:0] int_code,
  output logic              irq
);

  logic pend_q, raise;

  assign raise = (err_ie & err_chg) | (sts_ie & sts_chg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (raise)  pend_q <= 1'b1;
    else if (cpu_rd) pend_q <= 1'b0;
  end

  assign int_code = pend_q ? STATUS_CODE : '0;
  assign irq      = pend_q & glob_ie;

  AST_CODE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past((err_ie && err_chg) || (sts_ie && sts_chg))); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !((err_ie && err_chg) || (sts_ie && sts_chg))) |=> int_code == '0); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (glob_ie && int_code == STATUS_CODE)); // R10

endmodule

// File: rtl/can_status_unit.sv
module can_status_unit
  import can_stat_pkg::*;
#(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned WARN_LEVEL    = 96,
  parameter int unsigned PASSIVE_LEVEL = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_err_cnt,
  input  logic [CNT_W-1:0]  rx_err_cnt,
  input  logic              rx_passive,
  input  logic              bus_off_in,
  input  logic              ev_tx_ok,
  input  logic              ev_rx_ok,
  input  logic              ev_lec_upd,
  input  logic [LEC_W-1:0]  ev_lec,
  input  logic              err_ie,
  input  logic              sts_ie,
  input  logic              glob_ie,
  input  logic              cpu_wr,
  input  logic [4:0]        cpu_wdata,
  input  logic              cpu_rd,
  output logic [7:0]        stat_rdata,
  output logic              warn,
  output logic              err_passive,
  output logic              bus_off,
  output logic [CODE_W-1:0] int_code,
  output logic              irq
);

  logic         err_chg, sts_chg;
  xfer_fields_t fields_q;
  xfer_fields_t wr_fields;
  stat_byte_t   sbyte;

  assign wr_fields = xfer_fields_t'(cpu_wdata);

  can_err_level #(
    .CNT_W(CNT_W), .WARN_LEVEL(WARN_LEVEL), .PASSIVE_LEVEL(PASSIVE_LEVEL)
  ) u_level (
    .clk(clk), .rst_n(rst_n),
    .tx_cnt(tx_err_cnt), .rx_cnt(rx_err_cnt),
    .rx_passive(rx_passive), .bus_off_in(bus_off_in),
    .warn_q(warn), .passive_q(err_passive), .bus_off_q(bus_off),
    .err_chg(err_chg)
  );

  can_xfer_status u_xfer (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
    .ev_lec_upd(ev_lec_upd), .ev_lec(ev_lec),
    .cpu_wr(cpu_wr), .cpu_fields(wr_fields),
    .fields_q(fields_q), .hw_chg(sts_chg)
  );

  can_int_code u_int (
    .clk(clk), .rst_n(rst_n),
    .err_ie(err_ie), .sts_ie(sts_ie), .glob_ie(glob_ie),
    .err_chg(err_chg), .sts_chg(sts_chg), .cpu_rd(cpu_rd),
    .int_code(int_code), .irq(irq)
  );

  always_comb begin
    sbyte.bus_off = bus_off;
    sbyte.passive = err_passive;
    sbyte.warn    = warn;
    sbyte.tx_ok   = fields_q.tx_ok;
    sbyte.rx_ok   = fields_q.rx_ok;
    sbyte.lec     = fields_q.lec;
  end
  assign stat_rdata = sbyte;

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !(err_ie && err_chg)) |=> !$rose(int_code[CODE_W-1])); // R8
  AST_PASSIVE_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !err_chg && !cpu_rd) |=> $stable(int_code)); // R2
  AST_READONLY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !err_chg) |=> $stable({bus_off, warn})); // R3

endmodule

// File: tb/can_status_unit_bench.sv
module can_status_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tx_err_cnt = '0, rx_err_cnt = '0;
  logic        rx_passive = 1'b0, bus_off_in = 1'b0;
  logic        ev_tx_ok = 1'b0, ev_rx_ok = 1'b0, ev_lec_upd = 1'b0;
  logic [2:0]  ev_lec = '0;
  logic        err_ie = 1'b0, sts_ie = 1'b0, glob_ie = 1'b0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [4:0]  cpu_wdata = '0;
  logic [7:0]  stat_rdata;
  logic        warn, err_passive, bus_off, irq;
  logic [15:0] int_code;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // reference state
  bit m_warn, m_pas, m_bo, m_tx, m_rx, m_pend;
  bit [2:0] m_lec;

  always #2 clk = ~clk;

  can_status_unit u_can_status_unit (
    .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
    .rx_passive(rx_passive), .bus_off_in(bus_off_in), .ev_tx_ok(ev_tx_ok),
    .ev_rx_ok(ev_rx_ok), .ev_lec_upd(ev_lec_upd), .ev_lec(ev_lec),
    .err_ie(err_ie), .sts_ie(sts_ie), .glob_ie(glob_ie), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .stat_rdata(stat_rdata),
    .warn(warn), .err_passive(err_passive), .bus_off(bus_off),
    .int_code(int_code), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit [7:0] exp_byte();
    return {m_bo, m_pas, m_warn, m_tx, m_rx, m_lec};
  endfunction

  task automatic check_model();
    chk("R1", "warn", 16'(warn), 16'(m_warn));
    chk("R2", "err_passive", 16'(err_passive), 16'(m_pas));
    chk("R3", "bus_off", 16'(bus_off), 16'(m_bo));
    chk("R4", "stat_rdata", 16'(stat_rdata), 16'(exp_byte()));
    chk("R9", "int_code", int_code, m_pend ? 16'h8000 : 16'h0000);
    chk("R10", "irq", 16'(irq), 16'(m_pend && glob_ie));
  endtask

  // advance one edge with the current inputs, update model, check
  task automatic tick();
    bit nw, np, nb, ntx, nrx, echg, schg;
    bit [2:0] nl;
    nw = (tx_err_cnt >= 8'd96) || (rx_err_cnt >= 8'd96);
    np = rx_passive || (tx_err_cnt >= 8'd128);
    nb = bus_off_in;
    echg = (nw != m_warn) || (nb != m_bo);
    if (cpu_wr) begin
      ntx = cpu_wdata[4]; nrx = cpu_wdata[3]; nl = cpu_wdata[2:0]; schg = 1'b0;
    end else begin
      ntx = ev_tx_ok ? 1'b1 : m_tx;
      nrx = ev_rx_ok ? 1'b1 : m_rx;
      nl  = ev_lec_upd ? ev_lec : m_lec;
      schg = (ntx != m_tx) || (nrx != m_rx) || (nl != m_lec);
    end
    if ((err_ie && echg) || (sts_ie && schg)) m_pend = 1'b1;
    else if (cpu_rd) m_pend = 1'b0;
    m_warn = nw; m_pas = np; m_bo = nb; m_tx = ntx; m_rx = nrx; m_lec = nl;
    @(posedge clk);
    @(negedge clk);
    check_model();
    ev_tx_ok = 0; ev_rx_ok = 0; ev_lec_upd = 0; cpu_wr = 0; cpu_rd = 0;
  endtask

  function automatic logic [7:0] pick_cnt();
    case ($urandom_range(0, 7))
      0: return 8'd95;
      1: return 8'd96;
      2: return 8'd127;
      3: return 8'd128;
      4: return 8'd255;
      5: return 8'd0;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset stat_rdata", 16'(stat_rdata), 16'h0000);
    chk("R11", "reset int_code", int_code, 16'h0000);
    chk("R11", "reset irq", 16'(irq), 16'h0000);
    rst_n = 1'b1;
    tick();

    // R6 warning change with error enable, line gated off
    err_ie = 1; tx_err_cnt = 8'd96; tick();
    chk("R6", "warn raise code", int_code, 16'h8000);
    chk("R10", "irq gated", 16'(irq), 16'h0);
    glob_ie = 1; @(negedge clk);
    chk("R10", "irq enabled", 16'(irq), 16'h1);
    cpu_rd = 1; tick();
    chk("R9", "read clears", int_code, 16'h0000);

    // R2 passive change alone raises nothing
    tx_err_cnt = 8'd130; tick();
    chk("R2", "passive set", 16'(err_passive), 16'h1);
    chk("R2", "passive no code", int_code, 16'h0000);

    // R7 transfer events
    sts_ie = 1; ev_tx_ok = 1; tick();
    chk("R7", "tx_ok raises", int_code, 16'h8000);
    cpu_rd = 1; tick();
    ev_tx_ok = 1; tick();
    chk("R7", "repeat tx_ok no code", int_code, 16'h0000);
    ev_lec_upd = 1; ev_lec = 3'd3; tick();
    chk("R5", "lec loaded", 16'(stat_rdata[2:0]), 16'h3);
    cpu_rd = 1; tick();
    ev_lec_upd = 1; ev_lec = 3'd3; tick();
    chk("R7", "same lec no code", int_code, 16'h0000);

    // R8 / R5 CPU write overrides same-cycle event, no code
    cpu_wr = 1; cpu_wdata = 5'b01101; ev_tx_ok = 1; tick();
    chk("R5", "write wins", 16'(stat_rdata[4:0]), 16'h0D);
    chk("R8", "write no code", int_code, 16'h0000);

    // R3 error-state bits survive a write
    cpu_wr = 1; cpu_wdata = 5'b11111; tick();
    chk("R3", "readonly bits", 16'(stat_rdata[7:5]), 16'h3);

    // R9 read colliding with a new cause keeps the code
    cpu_wr = 1; cpu_wdata = 5'b00000; tick();
    cpu_rd = 1; ev_rx_ok = 1; tick();
    chk("R9", "read vs new cause", int_code, 16'h8000);
    cpu_rd = 1; tick();

    // R10 no late raise when the enable arrives after the change
    err_ie = 0; bus_off_in = 1; tick();
    chk("R3", "bus_off follows", 16'(bus_off), 16'h1);
    err_ie = 1; tick();
    chk("R10", "no late raise", int_code, 16'h0000);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tx_err_cnt = pick_cnt(); rx_err_cnt = pick_cnt();
      rx_passive = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) bus_off_in = ~bus_off_in;
      ev_tx_ok = ($urandom_range(0, 5) == 0);
      ev_rx_ok = ($urandom_range(0, 5) == 0);
      ev_lec_upd = ($urandom_range(0, 4) == 0);
      ev_lec = 3'($urandom_range(0, 7));
      cpu_wr = ($urandom_range(0, 6) == 0);
      cpu_wdata = 5'($urandom_range(0, 31));
      cpu_rd = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 31) == 0) err_ie = ~err_ie;
      if ($urandom_range(0, 31) == 0) sts_ie = ~sts_ie;
      if ($urandom_range(0, 31) == 0) glob_ie = ~glob_ie;
      tick();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule